// File: doc/BRIEF.md
# Measurement Gate Generator

This block produces the counting gate of a frequency counter. A reference gate signal, sampled in the system clock domain, supplies trigger edges. Two stages set when the gate opens and closes. An arming toggle stage is cleared by an active-low counter reset. Its outputs feed the J and K inputs of a gate flip-flop. As a result, the first trigger edge after a counter reset only arms the block, the second edge opens the gate, and the third edge closes it. After that close the arming stage stays idle until the next counter reset, so each measurement cycle gets exactly one gate.

Manual or external control can force the gate open or shut at any time through active-low set and clear inputs. An active-high reset input also forces the gate shut. Clear has priority over set. The block drives true and complement gate outputs. Whenever the gate goes from open to shut, whatever the cause, it also drives an active-low end-of-gate pulse that lasts one clock.

Top module: `ref_gate_gen`

## Requirements
- R1: During and after the synchronous reset `rst`, `gate` is 0, `gate_n` is 1 and `end_pulse_n` is 1.
- R2: While `cnt_rst_n` is 0 the arming stage is cleared. The first trigger edge after that only arms the block, and `gate` stays 0.
- R3: The second trigger edge after a counter reset sets `gate` to 1. The trigger edge is a 1-to-0 change of `ref_in` between two consecutive clock samples. `gate` changes on the clock edge that samples `ref_in` low.
- R4: The third trigger edge sets `gate` back to 0. Further trigger edges leave `gate` at 0 until the next counter reset.
- R5: When no override is active, `gate` changes only on a trigger edge. Rising or steady `ref_in` leaves it unchanged.
- R6: `man_set_n` = 0 (with no clear active) forces `gate` to 1 on the next clock edge, whatever `ref_in` is doing.
- R7: `man_clr_n` = 0 or `rst_in` = 1 forces `gate` to 0 on the next clock edge. This wins over `man_set_n` = 0 in the same cycle.
- R8: `gate_n` is always the complement of `gate`.
- R9: Every 1-to-0 change of `gate`, whatever its cause, drives `end_pulse_n` low in the same cycle for exactly one clock. At all other times `end_pulse_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference gate signal, synchronous to clk |
| cnt_rst_n | input | 1 | Active-low counter reset, clears the arming stage |
| man_set_n | input | 1 | Active-low manual/external gate set |
| man_clr_n | input | 1 | Active-low manual/external gate clear |
| rst_in | input | 1 | Active-high reset input, forces gate off |
| gate | output | 1 | Gate, 1 while open |
| gate_n | output | 1 | Complement of gate |
| end_pulse_n | output | 1 | One-clock active-low pulse when the gate closes |

## Verification
A wrong arming state shows up at the next trigger edge. Either the gate opens one edge early or late, or it reopens after its single measurement window. The per-cycle reference model flags this on that cycle. A lost or stretched end pulse, or a set that beats a clear, differs from the model one clock after the input that caused it. Random bursts of counter resets and overrides placed between trigger edges exercise the orderings that directed tests miss.

// File: rtl/gg_pkg.sv
package gg_pkg;
  typedef enum logic [1:0] {
    GCMD_HOLD  = 2'd0,
    GCMD_LOAD  = 2'd1,
    GCMD_SET   = 2'd2,
    GCMD_CLEAR = 2'd3
  } gate_cmd_e;

  // Clear beats set, set beats the edge-driven load.
  function automatic gate_cmd_e pick_cmd(input logic clr, input logic set, input logic trig);
    if (clr)       return GCMD_CLEAR;
    else if (set)  return GCMD_SET;
    else if (trig) return GCMD_LOAD;
    else           return GCMD_HOLD;
  endfunction
endpackage

// File: rtl/gg_edge_det.sv
module gg_edge_det #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic edge_o
);
  localparam bit PREV_INIT = !FALLING;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= PREV_INIT;
    else     prev_q <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~sig;
    end else begin : g_rise
      assign edge_o = ~prev_q & sig;
    end
  endgenerate
endmodule

// File: rtl/gg_arm.sv
module gg_arm (
  input  logic clk,
  input  logic rst,
  input  logic cnt_clr,
  input  logic trig,
  output logic arm_j,
  output logic arm_k
);
  logic arm_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      arm_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (trig) begin
      if (!done_q) arm_q <= ~arm_q;
      if (arm_q)   done_q <= 1'b1;
    end
  end

  assign arm_j = arm_q;
  assign arm_k = ~arm_q;

  AST_ARM_IDLE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (done_q && !cnt_clr) |=> !arm_q); // R4
endmodule

// File: rtl/gg_gate_ff.sv
module gg_gate_ff
  import gg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gate_cmd_e cmd,
  input  logic      j,
  input  logic      k,
  output logic      gate_q,
  output logic      gate_n_q,
  output logic      end_n_q
);
  logic gate_nxt;

  always_comb begin
    gate_nxt = gate_q;
    unique case (cmd)
      GCMD_CLEAR: gate_nxt = 1'b0;
      GCMD_SET:   gate_nxt = 1'b1;
      GCMD_LOAD: begin
        unique case ({j, k})
          2'b10:   gate_nxt = 1'b1;
          2'b01:   gate_nxt = 1'b0;
          2'b11:   gate_nxt = ~gate_q;
          default: gate_nxt = gate_q;
        endcase
      end
      default:    gate_nxt = gate_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b0;
      gate_n_q <= 1'b1;
      end_n_q  <= 1'b1;
    end else begin
      gate_q   <= gate_nxt;
      gate_n_q <= ~gate_nxt;
      end_n_q  <= ~(gate_q & ~gate_nxt);
    end
  end

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    gate_q != gate_n_q); // R8
  AST_PULSE_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) |-> !end_n_q); // R9
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    !end_n_q |=> end_n_q); // R9
endmodule

// File: rtl/ref_gate_gen.sv
module ref_gate_gen
  import gg_pkg::*;
#(
  parameter bit TRIG_FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic cnt_rst_n,
  input  logic man_set_n,
  input  logic man_clr_n,
  input  logic rst_in,
  output logic gate,
  output logic gate_n,
  output logic end_pulse_n
);
  logic      trig;
  logic      arm_j;
  logic      arm_k;
  logic      clr_req;
  logic      set_req;
  gate_cmd_e cmd;

  assign clr_req = ~man_clr_n | rst_in;
  assign set_req = ~man_set_n;
  assign cmd     = pick_cmd(clr_req, set_req, trig);

  gg_edge_det #(.FALLING(TRIG_FALLING)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig    (ref_in),
    .edge_o (trig)
  );

  gg_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .cnt_clr (~cnt_rst_n),
    .trig    (trig),
    .arm_j   (arm_j),
    .arm_k   (arm_k)
  );

  gg_gate_ff u_gate (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .j        (arm_j),
    .k        (arm_k),
    .gate_q   (gate),
    .gate_n_q (gate_n),
    .end_n_q  (end_pulse_n)
  );

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (!man_clr_n || rst_in) |=> !gate); // R7
  AST_SET_FORCES: assert property (@(posedge clk) disable iff (rst)
    (!man_set_n && man_clr_n && !rst_in) |=> gate); // R6
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!trig && man_set_n && man_clr_n && !rst_in) |=> $stable(gate)); // R5
endmodule

// File: tb/ref_gate_gen_bench.sv
`timescale 1ns/1ps
module ref_gate_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic cnt_rst_n = 1'b1;
  logic man_set_n = 1'b1;
  logic man_clr_n = 1'b1;
  logic rst_in = 1'b0;
  logic gate, gate_n, end_pulse_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  // reference model state
  logic m_gate = 1'b0, m_arm = 1'b0, m_done = 1'b0, m_prev = 1'b0, m_endn = 1'b1;

  always #4 clk = ~clk;

  ref_gate_gen u_ref_gate_gen (
    .clk(clk), .rst(rst), .ref_in(ref_in), .cnt_rst_n(cnt_rst_n),
    .man_set_n(man_set_n), .man_clr_n(man_clr_n), .rst_in(rst_in),
    .gate(gate), .gate_n(gate_n), .end_pulse_n(end_pulse_n)
  );

  function automatic logic next_gate(input logic g, input logic arm, input logic fall,
                                     input logic set_n, input logic clr_n, input logic rin);
    if (!clr_n || rin) return 1'b0;
    if (!set_n)        return 1'b1;
    if (fall)          return arm;
    return g;
  endfunction

  always @(posedge clk) begin
    logic fall, nxt;
    if (rst) begin
      m_gate = 0; m_arm = 0; m_done = 0; m_prev = 0; m_endn = 1;
    end else begin
      fall   = m_prev & ~ref_in;
      nxt    = next_gate(m_gate, m_arm, fall, man_set_n, man_clr_n, rst_in);
      m_endn = !(m_gate && !nxt);
      m_gate = nxt;
      if (!cnt_rst_n) begin
        m_arm = 0; m_done = 0;
      end else if (fall && !m_done) begin
        if (m_arm) m_done = 1;
        m_arm = ~m_arm;
      end
      m_prev = ref_in;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done_flag) begin
      chk("R5", "gate vs model", gate, m_gate);
      chk("R8", "gate_n vs model", gate_n, ~m_gate);
      chk("R9", "end_pulse_n vs model", end_pulse_n, m_endn);
    end
  end

  task automatic fall_edge();
    @(negedge clk) ref_in = 1'b1;
    @(negedge clk) ref_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic cnt_pulse();
    @(negedge clk) cnt_rst_n = 1'b0;
    @(negedge clk) cnt_rst_n = 1'b1;
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk("R1", "gate in reset", gate, 1'b0);
    chk("R1", "gate_n in reset", gate_n, 1'b1);
    chk("R1", "end_pulse_n in reset", end_pulse_n, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "gate after reset", gate, 1'b0);

    // directed sequence
    cnt_pulse();
    fall_edge();
    chk("R2", "gate after arming edge", gate, 1'b0);
    fall_edge();
    chk("R3", "gate after second edge", gate, 1'b1);
    chk("R8", "gate_n while open", gate_n, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5", "gate steady low ref", gate, 1'b1);
    ref_in = 1'b1;
    @(negedge clk);
    chk("R5", "gate after rising ref", gate, 1'b1);
    ref_in = 1'b0;
    @(negedge clk);
    chk("R4", "gate after third edge", gate, 1'b0);
    chk("R9", "end pulse on close", end_pulse_n, 1'b0);
    @(negedge clk);
    chk("R9", "end pulse released", end_pulse_n, 1'b1);
    fall_edge();
    chk("R4", "gate after fourth edge", gate, 1'b0);
    fall_edge();
    chk("R4", "gate after fifth edge", gate, 1'b0);

    // overrides
    man_set_n = 1'b0;
    @(negedge clk) man_set_n = 1'b1;
    chk("R6", "manual set", gate, 1'b1);
    man_clr_n = 1'b0;
    @(negedge clk) man_clr_n = 1'b1;
    chk("R7", "manual clear", gate, 1'b0);
    chk("R9", "end pulse on manual clear", end_pulse_n, 1'b0);
    man_set_n = 1'b0; man_clr_n = 1'b0;
    @(negedge clk) begin man_set_n = 1'b1; man_clr_n = 1'b1; end
    chk("R7", "clear beats set", gate, 1'b0);
    man_set_n = 1'b0;
    @(negedge clk) man_set_n = 1'b1;
    rst_in = 1'b1;
    @(negedge clk) rst_in = 1'b0;
    chk("R7", "reset input clears", gate, 1'b0);
    chk("R9", "end pulse on reset input", end_pulse_n, 1'b0);

    // second measurement cycle with rising ref during arming
    cnt_pulse();
    fall_edge();
    fall_edge();
    chk("R3", "gate reopens after new counter reset", gate, 1'b1);
    fall_edge();
    chk("R4", "gate closes again", gate, 1'b0);

    // constrained random phase, checked each cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ref_in    = ($urandom % 3) == 0 ? ~ref_in : ref_in;
      cnt_rst_n = ($urandom % 40) != 0;
      man_set_n = ($urandom % 60) != 0;
      man_clr_n = ($urandom % 70) != 0;
      rst_in    = ($urandom % 120) == 0;
    end
    @(negedge clk);
    man_set_n = 1'b1; man_clr_n = 1'b1; rst_in = 1'b0; cnt_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule